// File: doc/BRIEF.md
# EEPROM Save Sequencer

This block saves selected parts of a register map into an external EEPROM by following a short byte-coded script that is itself stored in the register map. When pulsed, it reads the script one byte at a time from a fixed base address. Each opcode either describes a run of registers to copy, marks a point at which the loader must apply the settings, or ends the script. Every opcode byte it accepts is also written into the EEPROM, so the stored image describes itself and a later loader can replay it.

For a copy run, the opcode's value N is followed by a two-byte source address, high byte first. The sequencer writes the opcode and both address bytes, then copies N+1 consecutive register bytes, then writes one checksum byte. It keeps its own EEPROM write pointer, which starts from zero. It waits for the EEPROM port's ready signal on every byte. If the image would grow past the EEPROM capacity, it stops and flags an error.

The state machine has eight states:

- **ST_IDLE** goes to **ST_FETCH_OP** when start is pulsed.
- **ST_FETCH_OP** sends a copy opcode to **ST_FETCH_AHI**. It sends the apply-settings and end opcodes to **ST_WRITE_HDR**. It sends an undefined opcode to **ST_DONE** with the error flag.
- **ST_FETCH_AHI** goes to **ST_FETCH_ALO**, and **ST_FETCH_ALO** goes to **ST_WRITE_HDR**.
- **ST_WRITE_HDR**, after its last header byte, goes to **ST_COPY** for a copy run. It returns to **ST_FETCH_OP** after an apply-settings opcode. It goes to **ST_DONE** with done after the end opcode.
- **ST_COPY** goes to **ST_WRITE_CSUM** after the last data byte.
- **ST_WRITE_CSUM** returns to **ST_FETCH_OP**.
- Any write state goes to **ST_DONE** with the error flag when the EEPROM is full.
- **ST_DONE** returns to **ST_IDLE**.

Top module: `eeprom_save_seq`

## Requirements
- R1: A start pulse in ST_IDLE raises busy on the next cycle, clears the EEPROM pointer, and begins reading the script at SCRIPT_BASE. The first EEPROM byte goes to address 0.
- R2: An opcode N from 0x00 to 0x7F copies N+1 bytes. They are read from consecutive register addresses, starting at the 16-bit address formed by the next two script bytes, with the first of these as the high byte. They are written to the EEPROM in that order.
- R3: For a copy run, the EEPROM receives, at consecutive addresses, the opcode byte, then the address high byte, then the address low byte, ahead of the data.
- R4: After the N+1 data bytes of a run, one checksum byte is written. It equals the two's complement (mod 256) of the 8-bit sum of those data bytes.
- R5: Opcode 0x80 (apply settings) takes no operands. It is written as a single EEPROM byte, and the script then continues with the next byte.
- R6: Opcode 0xFF (end) is written as a single EEPROM byte. The sequencer then stops with done high and error low.
- R7: An opcode from 0x81 to 0xFE is not written. The sequencer stops with error high and done low.
- R8: While ee_wr_valid is high and ee_wr_ready is low, ee_wr_valid, ee_wr_addr and ee_wr_data hold steady. A byte counts as written only on a cycle where both are high.
- R9: No write is issued at an EEPROM address of EE_DEPTH or above. A write that would need one stops the save with error high, after exactly EE_DEPTH bytes have been written.
- R10: A start pulse while busy is ignored, and the save in progress continues without disturbance.
- R11: Each register read presents rm_rd_en for one cycle and uses rm_rd_data one cycle later. Two reads are never issued back to back.
- R12: done and error are never high together. They stay set after the save, are cleared by the next accepted start, and busy is low once the sequencer is back in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a save; one-cycle pulse |
| busy | output | 1 | High while not in ST_IDLE |
| done | output | 1 | Save finished at an end opcode; sticky until next start |
| error | output | 1 | Save aborted (bad opcode or EEPROM full); sticky until next start |
| rm_rd_en | output | 1 | Register-map read strobe |
| rm_rd_addr | output | 16 | Register-map read address |
| rm_rd_data | input | 8 | Read data, valid the cycle after rm_rd_en |
| ee_wr_valid | output | 1 | EEPROM byte write request |
| ee_wr_ready | input | 1 | EEPROM accepts the byte this cycle |
| ee_wr_addr | output | $clog2(EE_DEPTH) | EEPROM byte address |
| ee_wr_data | output | 8 | EEPROM byte value |

## Verification
The assertions take for granted that the register map answers every read strobe one cycle later. They also take for granted that the EEPROM port's ready is free to stall for any length of time, and that the script ends in an end opcode, an undefined opcode or a full EEPROM, rather than running forever. The bench's memory model always answers with that one-cycle latency. It drives ready always high, with a stall every third cycle, or with a stall four cycles in five. Every script it stores ends in one of those three ways.

// File: rtl/esave_pkg.sv
package esave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_OP,
        ST_FETCH_AHI,
        ST_FETCH_ALO,
        ST_WRITE_HDR,
        ST_COPY,
        ST_WRITE_CSUM,
        ST_DONE
    } esave_state_e;

    localparam logic [7:0] OP_APPLY = 8'h80;
    localparam logic [7:0] OP_END   = 8'hFF;

    localparam logic [1:0] PH_ISSUE   = 2'd0;
    localparam logic [1:0] PH_CAPTURE = 2'd1;
    localparam logic [1:0] PH_WRITE   = 2'd2;

    function automatic logic op_is_copy(input logic [7:0] op);
        return !op[7];
    endfunction

endpackage

// File: rtl/esave_csum.sv
module esave_csum #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] csum
);

    logic [W-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clr) begin
            sum_q <= '0;
        end else if (add) begin
            sum_q <= sum_q + din;
        end
    end

    // R4: two's complement of the running sum
    assign csum = (~sum_q) + W'(1);

endmodule

// File: rtl/esave_ptr.sv
module esave_ptr #(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [PW-1:0] ptr,
    output logic          full
);

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clr) begin
            ptr_q <= '0;
        end else if (inc) begin
            ptr_q <= ptr_q + PW'(1);
        end
    end

    assign ptr  = ptr_q;
    assign full = (ptr_q >= PW'(DEPTH));

    // R9: an accepted write never happens at or beyond capacity
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (ptr_q < PW'(DEPTH)));

endmodule

// File: rtl/eeprom_save_seq.sv
module eeprom_save_seq
    import esave_pkg::*;
#(
    parameter logic [15:0] SCRIPT_BASE = 16'h0E15,
    parameter int unsigned EE_DEPTH    = 128,
    localparam int unsigned EE_AW      = $clog2(EE_DEPTH),
    localparam int unsigned PW         = $clog2(EE_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             rm_rd_en,
    output logic [15:0]      rm_rd_addr,
    input  logic [7:0]       rm_rd_data,
    output logic             ee_wr_valid,
    input  logic             ee_wr_ready,
    output logic [EE_AW-1:0] ee_wr_addr,
    output logic [7:0]       ee_wr_data
);

    esave_state_e state_q, state_d;
    logic [1:0]   ph_q;
    logic [15:0]  sp_q;
    logic [15:0]  src_q;
    logic [6:0]   cnt_q;
    logic [7:0]   op_q;
    logic [7:0]   byte_q;
    logic [1:0]   hdr_idx_q;
    logic [1:0]   hdr_last;
    logic         done_q, err_q;
    logic         set_done, set_err;
    logic         wr_fire;
    logic         accept_start;
    logic [PW-1:0] ptr;
    logic         full;
    logic [7:0]   csum;
    logic         sum_add;

    assign accept_start = (state_q == ST_IDLE) && start;
    assign wr_fire      = ee_wr_valid && ee_wr_ready;
    assign hdr_last     = op_is_copy(op_q) ? 2'd2 : 2'd0;
    assign sum_add      = (state_q == ST_COPY) && (ph_q == PH_CAPTURE);

    esave_ptr #(.DEPTH(EE_DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept_start),
        .inc   (wr_fire),
        .ptr   (ptr),
        .full  (full)
    );

    esave_csum #(.W(8)) u_csum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_FETCH_OP),
        .add   (sum_add),
        .din   (rm_rd_data),
        .csum  (csum)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        set_done = 1'b0;
        set_err  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_FETCH_OP;
            end
            ST_FETCH_OP: begin
                if (ph_q == PH_CAPTURE) begin
                    if (op_is_copy(rm_rd_data)) begin
                        state_d = ST_FETCH_AHI;
                    end else if (rm_rd_data == OP_APPLY || rm_rd_data == OP_END) begin
                        state_d = ST_WRITE_HDR;
                    end else begin
                        state_d = ST_DONE;
                        set_err = 1'b1;
                    end
                end
            end
            ST_FETCH_AHI: begin
                if (ph_q == PH_CAPTURE) state_d = ST_FETCH_ALO;
            end
            ST_FETCH_ALO: begin
                if (ph_q == PH_CAPTURE) state_d = ST_WRITE_HDR;
            end
            ST_WRITE_HDR: begin
                if (full) begin
                    state_d = ST_DONE;
                    set_err = 1'b1;
                end else if (wr_fire && hdr_idx_q == hdr_last) begin
                    if (op_is_copy(op_q)) begin
                        state_d = ST_COPY;
                    end else if (op_q == OP_END) begin
                        state_d  = ST_DONE;
                        set_done = 1'b1;
                    end else begin
                        state_d = ST_FETCH_OP;
                    end
                end
            end
            ST_COPY: begin
                if (ph_q == PH_WRITE) begin
                    if (full) begin
                        state_d = ST_DONE;
                        set_err = 1'b1;
                    end else if (wr_fire && cnt_q == 7'd0) begin
                        state_d = ST_WRITE_CSUM;
                    end
                end
            end
            ST_WRITE_CSUM: begin
                if (full) begin
                    state_d = ST_DONE;
                    set_err = 1'b1;
                end else if (wr_fire) begin
                    state_d = ST_FETCH_OP;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ph_q      <= PH_ISSUE;
            sp_q      <= '0;
            src_q     <= '0;
            cnt_q     <= '0;
            op_q      <= '0;
            byte_q    <= '0;
            hdr_idx_q <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_start) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
                sp_q   <= SCRIPT_BASE;
                ph_q   <= PH_ISSUE;
            end
            if (set_done) done_q <= 1'b1;
            if (set_err)  err_q  <= 1'b1;
            unique case (state_q)
                ST_FETCH_OP: begin
                    if (ph_q == PH_ISSUE) begin
                        ph_q <= PH_CAPTURE;
                    end else begin
                        op_q      <= rm_rd_data;
                        cnt_q     <= rm_rd_data[6:0];
                        sp_q      <= sp_q + 16'd1;
                        hdr_idx_q <= 2'd0;
                        ph_q      <= PH_ISSUE;
                    end
                end
                ST_FETCH_AHI: begin
                    if (ph_q == PH_ISSUE) begin
                        ph_q <= PH_CAPTURE;
                    end else begin
                        src_q[15:8] <= rm_rd_data;
                        sp_q        <= sp_q + 16'd1;
                        ph_q        <= PH_ISSUE;
                    end
                end
                ST_FETCH_ALO: begin
                    if (ph_q == PH_ISSUE) begin
                        ph_q <= PH_CAPTURE;
                    end else begin
                        src_q[7:0] <= rm_rd_data;
                        sp_q       <= sp_q + 16'd1;
                        hdr_idx_q  <= 2'd0;
                        ph_q       <= PH_ISSUE;
                    end
                end
                ST_WRITE_HDR: begin
                    if (wr_fire) hdr_idx_q <= hdr_idx_q + 2'd1;
                end
                ST_COPY: begin
                    if (ph_q == PH_ISSUE) begin
                        ph_q <= PH_CAPTURE;
                    end else if (ph_q == PH_CAPTURE) begin
                        byte_q <= rm_rd_data;
                        src_q  <= src_q + 16'd1;
                        ph_q   <= PH_WRITE;
                    end else if (wr_fire) begin
                        ph_q <= PH_ISSUE;
                        if (cnt_q != 7'd0) cnt_q <= cnt_q - 7'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rm_rd_en    = 1'b0;
        rm_rd_addr  = sp_q;
        ee_wr_valid = 1'b0;
        ee_wr_data  = 8'h00;
        unique case (state_q)
            ST_FETCH_OP, ST_FETCH_AHI, ST_FETCH_ALO: begin
                rm_rd_en = (ph_q == PH_ISSUE);
            end
            ST_WRITE_HDR: begin
                ee_wr_valid = !full;
                unique case (hdr_idx_q)
                    2'd0:    ee_wr_data = op_q;
                    2'd1:    ee_wr_data = src_q[15:8];
                    default: ee_wr_data = src_q[7:0];
                endcase
            end
            ST_COPY: begin
                rm_rd_en    = (ph_q == PH_ISSUE);
                rm_rd_addr  = src_q;
                ee_wr_valid = (ph_q == PH_WRITE) && !full;
                ee_wr_data  = byte_q;
            end
            ST_WRITE_CSUM: begin
                ee_wr_valid = !full;
                ee_wr_data  = csum;
            end
            default: ;
        endcase
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign error      = err_q;
    assign ee_wr_addr = ptr[EE_AW-1:0];

    // R1: each save starts writing at EEPROM address zero
    a_r1_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ptr == '0));

    // R8: a pending write holds steady until accepted
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_wr_valid && !ee_wr_ready) |=>
            (ee_wr_valid && $stable(ee_wr_data) && $stable(ee_wr_addr)));

    // R11: reads are single-cycle strobes, never back to back
    a_r11_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        rm_rd_en |=> !rm_rd_en);

    // R12: outcome flags exclusive
    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

endmodule

// File: tb/sim_eeprom_save_seq.sv
module sim_eeprom_save_seq;

    localparam logic [15:0] BASE  = 16'h0E15;
    localparam int          DEPTH = 128;
    localparam int          AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, error;
    logic          rm_rd_en;
    logic [15:0]   rm_rd_addr;
    logic [7:0]    rm_rd_data = 8'h00;
    logic          ee_wr_valid;
    logic          ee_wr_ready = 1'b0;
    logic [AW-1:0] ee_wr_addr;
    logic [7:0]    ee_wr_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rdy_mode = 0;

    logic [7:0] sc [0:15];
    logic [7:0] exp_b [0:255];
    int         exp_t [0:255];
    int         exp_n;
    bit         exp_done, exp_err;
    int         widx;

    bit         prev_pend = 1'b0;
    logic [7:0] prev_data;
    logic [AW-1:0] prev_addr;

    always #5 clk = ~clk;

    eeprom_save_seq #(.SCRIPT_BASE(BASE), .EE_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .error(error), .rm_rd_en(rm_rd_en), .rm_rd_addr(rm_rd_addr),
        .rm_rd_data(rm_rd_data), .ee_wr_valid(ee_wr_valid),
        .ee_wr_ready(ee_wr_ready), .ee_wr_addr(ee_wr_addr),
        .ee_wr_data(ee_wr_data)
    );

    function automatic logic [7:0] mb(input int a);
        if (a >= int'(BASE) && a < int'(BASE) + 16) return sc[a - int'(BASE)];
        return 8'((a * 37) ^ (a >> 5));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // register map: answers one cycle after the strobe (R11)
    always @(posedge clk) if (rm_rd_en) rm_rd_data <= mb(int'(rm_rd_addr));

    // ready patterns
    always @(posedge clk) begin
        cyc++;
        #2;
        case (rdy_mode)
            0:       ee_wr_ready <= 1'b1;
            1:       ee_wr_ready <= (cyc % 3) != 0;
            default: ee_wr_ready <= (cyc % 5) == 0;
        endcase
    end

    // watchdog
    always @(posedge clk) if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // per-clock comparison against the reference image
    always @(negedge clk) if (rst_n) begin
        if (prev_pend) begin // R8
            chk(ee_wr_valid && ee_wr_data == prev_data && ee_wr_addr == prev_addr,
                "R8 hold", {ee_wr_valid, ee_wr_data}, {1'b1, prev_data});
        end
        prev_pend = ee_wr_valid && !ee_wr_ready;
        prev_data = ee_wr_data;
        prev_addr = ee_wr_addr;
        if (ee_wr_valid && ee_wr_ready) begin
            if (widx >= exp_n) begin
                chk(1'b0, "R9/R7 extra write", widx, exp_n);
            end else begin
                checks++;
                if (ee_wr_data != exp_b[widx] || int'(ee_wr_addr) != widx) begin
                    fails++;
                    $display("FAIL R%0d byte %0d actual=0x%0h@%0d expected=0x%0h@%0d",
                             exp_t[widx], widx, ee_wr_data, ee_wr_addr, exp_b[widx], widx);
                end
            end
            widx++;
        end
    end

    task automatic push(input logic [7:0] b, input int tag, inout bit ovf);
        if (exp_n >= DEPTH) ovf = 1'b1;
        else begin
            exp_b[exp_n] = b;
            exp_t[exp_n] = tag;
            exp_n++;
        end
    endtask

    // behavioural reference: walk the script, build the expected image
    task automatic build_expect();
        int  sp = int'(BASE);
        bit  ovf = 1'b0;
        bit  fin = 1'b0;
        exp_n = 0; exp_done = 1'b0; exp_err = 1'b0;
        while (!fin && !ovf) begin
            logic [7:0] op = mb(sp);
            sp++;
            if (op < 8'h80) begin
                int a;
                int sum = 0;
                push(op, 3, ovf);          // R3
                push(mb(sp), 3, ovf);
                push(mb(sp + 1), 3, ovf);
                a = (int'(mb(sp)) << 8) | int'(mb(sp + 1));
                sp += 2;
                for (int k = 0; k <= int'(op); k++) begin
                    push(mb(a + k), 2, ovf);  // R2
                    sum += int'(mb(a + k));
                end
                push(8'((256 - (sum % 256)) % 256), 4, ovf); // R4
            end else if (op == 8'h80) begin
                push(op, 5, ovf);          // R5
            end else if (op == 8'hFF) begin
                push(op, 6, ovf);          // R6
                fin = 1'b1;
                if (!ovf) exp_done = 1'b1;
            end else begin
                fin = 1'b1;                // R7
                exp_err = 1'b1;
            end
        end
        if (ovf) begin                     // R9
            exp_err  = 1'b1;
            exp_done = 1'b0;
        end
    endtask

    task automatic run_save(input string name, input bit poke_mid);
        int guard = 0;
        build_expect();
        widx = 0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(busy && !done && !error, {"R1/R12 start ", name}, {busy, done, error}, 3'b100);
        if (poke_mid) begin                // R10: start while busy ignored
            repeat (40) @(negedge clk);
            #1 start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(!busy, {"R12 idle ", name}, busy, 0);
        chk(widx == exp_n, {"R9/R2 count ", name}, widx, exp_n);
        chk(done == exp_done, {"R6/R12 done ", name}, done, exp_done);
        chk(error == exp_err, {"R7/R9 error ", name}, error, exp_err);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) sc[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // reset state
        chk(!busy && !done && !error && !ee_wr_valid && !rm_rd_en, "R12 reset",
            {busy, done, error, ee_wr_valid, rm_rd_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // default script: three runs, apply, end
        sc[0] = 8'h14; sc[1] = 8'h02; sc[2] = 8'h00;
        sc[3] = 8'h1B; sc[4] = 8'h03; sc[5] = 8'h00;
        sc[6] = 8'h19; sc[7] = 8'h04; sc[8] = 8'h00;
        sc[9] = 8'h80; sc[10] = 8'hFF;
        rdy_mode = 1;
        run_save("default", 1'b0);
        rdy_mode = 0;
        run_save("default-restart", 1'b1);   // R10

        // apply, single-byte run, undefined opcode (R5, R7)
        sc[0] = 8'h80; sc[1] = 8'h00; sc[2] = 8'h00; sc[3] = 8'h10; sc[4] = 8'hC3;
        rdy_mode = 2;
        run_save("bad-op", 1'b0);

        // exactly fills the EEPROM: 3 + 123 + 1 + 1 = 128 (R9 boundary)
        sc[0] = 8'h7A; sc[1] = 8'h05; sc[2] = 8'h00; sc[3] = 8'hFF;
        rdy_mode = 1;
        run_save("exact-fill", 1'b0);

        // overflows the EEPROM (R9)
        sc[0] = 8'h7F; sc[1] = 8'h06; sc[2] = 8'h00; sc[3] = 8'hFF;
        rdy_mode = 0;
        run_save("overflow", 1'b0);

        // restart after error clears flags, then a plain end script (R12, R6)
        sc[0] = 8'hFF;
        run_save("end-only", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule